// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns the synchronized inputs of an 8-pin GPIO port into per-pin interrupt conditions. It merges those conditions into one port interrupt line. Each pin has its own configuration.

- Detection kind: edge or level.
- Edge selection: a single edge or both edges.
- Polarity: rising edge or high level, or falling edge or low level.

Edge events are held in a per-pin latch until software clears them. Level conditions track the pin directly. Software sees the raw conditions separately from the conditions that survive the enable mask.

The block sits behind a simple register bus. A write is a single-cycle strobe with an address and data. Reads are combinational from the address. Software sets the configuration and the mask, polls the raw and masked status, and clears latched edges by writing ones to the clear register. The pin synchronizers and the interrupt controller that receives the line are outside the block.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every register reads 0x00 and irq_o is low; all interrupts start masked.
- R2: Offsets 0 (kind: 1 = level, 0 = edge), 1 (both-edges), 2 (polarity) and 3 (enable mask) are read/write and read back what was written. Offset 4 reads raw status and offset 5 reads masked status; writes to either are ignored. Offset 6 is the write-only clear register and reads 0x00. Offset 7 reads 0x00.
- R3: A pin in edge mode with both-edges 0 latches its raw bit on a rising edge when polarity is 1, and on a falling edge when polarity is 0.
- R4: A pin in edge mode with both-edges 1 latches on either edge, whatever its polarity bit.
- R5: A pin in level mode shows raw 1 exactly while its input equals its polarity bit (1 = high, 0 = low). The bit follows the input in the same cycle, and both-edges has no effect.
- R6: A latched edge bit stays set until a clear write puts a 1 in that bit position. Clear bits written as 0 leave it set.
- R7: A clear write has no effect on the raw bit of a pin in level mode.
- R8: When an edge is detected in the same cycle as a clear write to that bit, the bit stays set.
- R9: Masked status equals raw status AND the enable mask. Raw status is independent of the mask.
- R10: irq_o is the OR of all masked status bits. It is low whenever the mask is zero.
- R11: An edge is found by comparing the input with its value one clock earlier. It appears in raw status after the clock edge that samples the changed input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data, one bit per pin |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| pins_i | input | 8 | Synchronized pin inputs |
| irq_o | output | 1 | Port interrupt |

## Verification
A corrupted previous-value register shows up as a spurious or missing raw bit in the cycle after the pin changes. A stuck edge latch shows up at the next clear write, when the raw bit fails to drop, or at the next edge, when it fails to rise. A configuration bit that is decoded wrongly shows up within one step of the per-pin sweep. In that sweep every pin passes through all eight combinations of kind, both-edges and polarity. Mask or merge faults show up at once in the masked readback and in irq_o, because both are combinational from raw status.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_KIND   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_POL    = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 3'd6;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] kind_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] clr_o
);
  logic [NUM_PINS-1:0] kind_q, both_q, pol_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_KIND: kind_q <= wdata_i;
        OFS_BOTH: both_q <= wdata_i;
        OFS_POL:  pol_q  <= wdata_i;
        OFS_MASK: mask_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  // clear is a one-cycle pulse, never stored
  assign clr_o  = (we_i && addr_i == OFS_CLEAR) ? wdata_i : '0;
  assign kind_o = kind_q;
  assign both_o = both_q;
  assign pol_o  = pol_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic kind_i,   // 1 = level
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic evt_o,
  output logic lat_o,
  output logic raw_o
);
  logic prev_q, lat_q;
  logic rise, fall, edge_hit, level_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      lat_q  <= evt_o | (lat_q & ~clr_i);  // new edge beats clear
    end
  end

  always_comb begin
    rise      = pin_i & ~prev_q;
    fall      = ~pin_i & prev_q;
    edge_hit  = both_i ? (rise | fall) : (pol_i ? rise : fall);
    level_hit = pol_i ? pin_i : ~pin_i;
  end

  assign evt_o = edge_hit & ~kind_i;
  assign lat_o = lat_q;
  assign raw_o = kind_i ? level_hit : lat_q;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] raw_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] masked_o,
  output logic                irq_o
);
  assign masked_o = raw_i & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] kind_q, both_q, pol_q, mask_q, clr_w;
  logic [NUM_PINS-1:0] evt_w, lat_w, raw_w, masked_w;

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .kind_o  (kind_q),
    .both_o  (both_q),
    .pol_o   (pol_q),
    .mask_o  (mask_q),
    .clr_o   (clr_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins_i[i]),
      .kind_i (kind_q[i]),
      .both_i (both_q[i]),
      .pol_i  (pol_q[i]),
      .clr_i  (clr_w[i]),
      .evt_o  (evt_w[i]),
      .lat_o  (lat_w[i]),
      .raw_o  (raw_w[i])
    );
  end

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .raw_i    (raw_w),
    .mask_i   (mask_q),
    .masked_o (masked_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      OFS_KIND:   reg_rdata_o = kind_q;
      OFS_BOTH:   reg_rdata_o = both_q;
      OFS_POL:    reg_rdata_o = pol_q;
      OFS_MASK:   reg_rdata_o = mask_q;
      OFS_RAW:    reg_rdata_o = raw_w;
      OFS_MASKED: reg_rdata_o = masked_w;
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pins_i,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] kind_i,
  input logic [NUM_PINS-1:0] pol_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] raw_i,
  input logic [NUM_PINS-1:0] lat_i,
  input logic [NUM_PINS-1:0] evt_i,
  input logic [NUM_PINS-1:0] clr_i
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_RESET_IRQ_LOW: assert property (@(posedge clk_i) !rst_ni |-> !irq_o); // R1
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o); // R10
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kind_i & ((pol_i & ~pins_i) | (~pol_i & pins_i)) & raw_i) == '0)); // R5
  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> (($past(evt_i) & ~lat_i) == '0)); // R3
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> (($past(lat_i & ~clr_i) & ~lat_i) == '0)); // R6
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> (($past(evt_i & clr_i) & ~lat_i) == '0)); // R8
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pins_i (pins_i),
  .irq_o  (irq_o),
  .kind_i (kind_q),
  .pol_i  (pol_q),
  .mask_i (mask_q),
  .raw_i  (raw_w),
  .lat_i  (lat_w),
  .evt_i  (evt_w),
  .clr_i  (clr_w)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pins = 8'h00;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0] m_kind = 0, m_both = 0, m_pol = 0, m_mask = 0, m_prev = 0, m_lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pins_i(pins), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_raw(input logic [7:0] p);
    return (m_kind & ((m_pol & p) | (~m_pol & ~p))) | (~m_kind & m_lat);
  endfunction

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  // one clock: new pin value, optional clear write, then check status
  task automatic step(input string tag, input logic [7:0] p, input logic [7:0] clr);
    logic [7:0] rise, fall, hit, evt, d;
    @(negedge clk);
    pins = p;
    we = (clr != 0); addr = 3'd6; wdata = clr;
    @(posedge clk);
    rise = p & ~m_prev;
    fall = ~p & m_prev;
    hit  = (m_both & (rise | fall)) | (~m_both & ((m_pol & rise) | (~m_pol & fall)));
    evt  = hit & ~m_kind;
    m_lat  = evt | (m_lat & ~clr);
    m_prev = p;
    @(negedge clk);
    we = 1'b0;
    rd(3'd4, d); chk({tag, " raw"}, d, exp_raw(p));
    rd(3'd5, d); chk({tag, " R9 masked"}, d, exp_raw(p) & m_mask);
    chk({tag, " R10 irq"}, {7'd0, irq}, {7'd0, |(exp_raw(p) & m_mask)});
  endtask

  task automatic cfg(input logic [7:0] k, input logic [7:0] b, input logic [7:0] po, input logic [7:0] mk);
    logic [7:0] d;
    wr(3'd0, k); wr(3'd1, b); wr(3'd2, po); wr(3'd3, mk);
    m_kind = k; m_both = b; m_pol = po; m_mask = mk;
    rd(3'd0, d); chk("R2 kind readback", d, k);
    rd(3'd1, d); chk("R2 both readback", d, b);
    rd(3'd2, d); chk("R2 pol readback", d, po);
    rd(3'd3, d); chk("R2 mask readback", d, mk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); chk("R1 reset value", d, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    // R10: conditions present but mask zero
    cfg(8'hFF, 8'h00, 8'h00, 8'h00);
    step("R10 mask zero", 8'h00, 8'h00);
    chk("R10 irq low with mask zero", {7'd0, irq}, 8'h00);

    // R2: status/unused offsets
    wr(3'd4, 8'h00); rd(3'd4, d); chk("R2 raw write ignored", d, 8'hFF);
    wr(3'd5, 8'h00); rd(3'd5, d); chk("R2 masked write ignored", d, 8'h00);
    rd(3'd6, d); chk("R2 clear reads zero", d, 8'h00);
    rd(3'd7, d); chk("R2 unused reads zero", d, 8'h00);

    // R7: clear on level pins
    step("R7 clear level", 8'h00, 8'hFF);
    rd(3'd4, d); chk("R7 level bits unaffected", d, 8'hFF);

    // R3/R11 rising, R6 hold, R8 collision
    cfg(8'h00, 8'h00, 8'hFF, 8'hFF);
    step("R11 settle", 8'h00, 8'hFF);
    step("R8 edge with clear", 8'hFF, 8'hFF);
    rd(3'd4, d); chk("R8 edge wins", d, 8'hFF);
    step("R6 clear zero", 8'hFF, 8'h00);
    rd(3'd4, d); chk("R6 zero-write no effect", d, 8'hFF);
    step("R6 partial clear", 8'hFF, 8'h0F);
    rd(3'd4, d); chk("R6 partial clear", d, 8'hF0);
    step("R3 falling ignored", 8'h00, 8'hFF);
    rd(3'd4, d); chk("R3 no latch on fall with pol 1", d, 8'h00);

    // R4: both edges, pol 0 ignored
    cfg(8'h00, 8'hFF, 8'h00, 8'hFF);
    step("R4 rise", 8'hFF, 8'h00);
    rd(3'd4, d); chk("R4 rise latches", d, 8'hFF);

    // exhaustive per-pin config rotation: R3 R4 R5 R6 R8 R9 R10 R11
    for (int c = 0; c < 8; c++) begin
      logic [7:0] k, b, po, mk;
      for (int i = 0; i < 8; i++) begin
        k[i]  = ((c + i) >> 2) & 1;
        b[i]  = ((c + i) >> 1) & 1;
        po[i] = (c + i) & 1;
      end
      mk = 8'hFF ^ 8'(c * 8'h13);
      cfg(k, b, po, mk);
      step("R6 sweep clear", pins, 8'hFF);
      for (int s = 0; s < 24; s++) begin
        logic [7:0] p, cl;
        p  = 8'((s * 8'h35) ^ (c * 8'h1D) ^ (s >> 1));
        cl = (s % 3 == 2) ? 8'(8'h33 << (s % 4)) : 8'h00;
        step("R3 R4 R5 R8 R11 sweep", p, cl);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule